// File: doc/BRIEF.md
# Exception and Interrupt Event Priority Resolver

This block sits in front of the exception entry logic of a processor core. Each cycle it looks at every pending event source and picks one: a reset request, a machine check, an init request, a system-management request, a trap left by the previous instruction (including a software interrupt with its own vector operand), a non-maskable interrupt, a maskable interrupt gated by a global enable, an execution-stage fault, a fetch-side translation or protection fault, and an illegal-opcode fault. It presents the winner as a registered class code, a vector number and a one-cycle valid strobe.

Request lines are levels owned by their requesters. The resolver consumes nothing except its own latched non-maskable edge. A source that loses therefore stays visible and is chosen again once the entry logic reports that the winning entry is done. A second non-maskable edge that arrives while a non-maskable handler is running is held back until the return-from-interrupt pulse. All other sources can still nest during that time.

Top module: `exc_prio_resolver`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises with no request present, `exc_valid` is 0.
- R2: When several sources are eligible together, the one taken is the first in this order: reset request, machine check, init, system management, trap, non-maskable interrupt, maskable interrupt, execution fault, fetch fault, illegal opcode.
- R3: `exc_class` encodes 0 = fault, 1 = trap, 2 = interrupt, 3 = abort. Reset request and machine check report abort. Trap reports trap. Init, system management, non-maskable and maskable interrupts report interrupt. Execution, fetch and illegal-opcode events report fault.
- R4: With default parameters, `exc_vec` is 255 for reset request, 18 for machine check, 254 for init, 253 for system management, 2 for the non-maskable interrupt and 6 for illegal opcode. Execution and fetch faults report `exe_vec` and `fetch_vec`.
- R5: A maskable request is ignored while `irq_en` is 0, and then produces no strobe. When it is taken, its vector is `irq_vec`.
- R6: A rising edge on `nmi_in` is latched and taken regardless of `irq_en`, even if `nmi_in` later falls.
- R7: Once a non-maskable entry is issued, a further `nmi_in` edge is held pending until an `iret` pulse. Other sources are still taken meanwhile.
- R8: `exc_valid` rises on the clock edge after an eligible source is sampled with no entry in progress, stays high exactly one cycle, and does not rise again until `entry_done` has been pulsed.
- R9: After `entry_done`, any source still requesting, whether a loser or the still-asserted previous winner, is presented again.
- R10: A trap reports `trap_vec` as its vector and is taken regardless of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the resolver |
| rst_req | input | 1 | Hardware reset event request |
| mchk_req | input | 1 | Machine check request |
| init_req | input | 1 | Init request |
| smi_req | input | 1 | System-management request |
| trap_req | input | 1 | Trap pending from the previous instruction |
| trap_vec | input | VEC_W | Trap / software interrupt vector operand |
| nmi_in | input | 1 | Non-maskable interrupt line (edge sensitive) |
| irq_req | input | 1 | Maskable interrupt request |
| irq_vec | input | VEC_W | Vector supplied by the external controller |
| irq_en | input | 1 | Global maskable interrupt enable |
| exe_req | input | 1 | Execution-stage fault pending |
| exe_vec | input | VEC_W | Vector of the execution-stage fault |
| fetch_req | input | 1 | Fetch translation / protection fault pending |
| fetch_vec | input | VEC_W | Vector of the fetch fault |
| ud_req | input | 1 | Illegal opcode fault pending |
| entry_done | input | 1 | Entry logic finished with the presented event |
| iret | input | 1 | Return from interrupt handler |
| exc_valid | output | 1 | One-cycle strobe for a selected event |
| exc_class | output | 2 | Class of the selected event |
| exc_vec | output | VEC_W | Vector of the selected event |

## Verification
The assertions assume that requesters hold their lines as levels and drop a winner's request themselves after its entry is done. They also assume that `entry_done` and `iret` are single-cycle pulses that arrive only after a strobe. The stimulus follows this: it lowers exactly the served source's line in the cycle it pulses `entry_done`, and it pulses `iret` only while a non-maskable handler is outstanding. Vectors are driven stable for as long as their request is high, so the registered vector compared by the scoreboard is well defined.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

   typedef enum logic [1:0] {
      CLS_FAULT = 2'd0,
      CLS_TRAP  = 2'd1,
      CLS_INTR  = 2'd2,
      CLS_ABORT = 2'd3
   } exc_class_e;

   // Source slots, lower index wins
   localparam int SRC_RST   = 0;
   localparam int SRC_MCHK  = 1;
   localparam int SRC_INIT  = 2;
   localparam int SRC_SMI   = 3;
   localparam int SRC_TRAP  = 4;
   localparam int SRC_NMI   = 5;
   localparam int SRC_IRQ   = 6;
   localparam int SRC_EXE   = 7;
   localparam int SRC_FETCH = 8;
   localparam int SRC_UD    = 9;
   localparam int NSRC      = 10;

endpackage

// File: rtl/exc_prio_penc.sv
module exc_prio_penc #(
   parameter int N  = 10,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   if (N < 2) begin : g_chk
      $error("exc_prio_penc: N must be at least 2");
   end

   assign grant[0] = req[0];
   for (genvar i = 1; i < N; i++) begin : g_grant
      assign grant[i] = req[i] & ~(|req[i-1:0]);
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

   always_comb begin
      assert_grant_onehot_R2: assert ($onehot0(grant));
      assert_grant_subset_R2: assert ((grant & ~req) == '0);
   end

endmodule

// File: rtl/exc_nmi_gate.sv
module exc_nmi_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic take,
   input  logic iret,
   output logic eligible
);

   logic nmi_q, pend_q, active_q;
   logic edge_seen;

   assign edge_seen = nmi_in & ~nmi_q;
   assign eligible  = pend_q & ~active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q    <= 1'b0;
         pend_q   <= 1'b0;
         active_q <= 1'b0;
      end else begin
         nmi_q <= nmi_in;
         if (take)           pend_q <= 1'b0;
         else if (edge_seen) pend_q <= 1'b1;
         if (take)           active_q <= 1'b1;
         else if (iret)      active_q <= 1'b0;
      end
   end

   assert_nmi_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !take) |=> pend_q);
   assert_nmi_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !iret) |=> active_q);

endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
   import exc_prio_pkg::*;
#(
   parameter int          VEC_W     = 8,
   parameter logic [31:0] RESET_VEC = 32'd255,
   parameter logic [31:0] MCHK_VEC  = 32'd18,
   parameter logic [31:0] INIT_VEC  = 32'd254,
   parameter logic [31:0] SMI_VEC   = 32'd253,
   parameter logic [31:0] NMI_VEC   = 32'd2,
   parameter logic [31:0] UD_VEC    = 32'd6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_req,
   input  logic             mchk_req,
   input  logic             init_req,
   input  logic             smi_req,
   input  logic             trap_req,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic             nmi_in,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             irq_en,
   input  logic             exe_req,
   input  logic [VEC_W-1:0] exe_vec,
   input  logic             fetch_req,
   input  logic [VEC_W-1:0] fetch_vec,
   input  logic             ud_req,
   input  logic             entry_done,
   input  logic             iret,
   output logic             exc_valid,
   output logic [1:0]       exc_class,
   output logic [VEC_W-1:0] exc_vec
);

   localparam int IW      = $clog2(NSRC);
   localparam int VEC_MAX = (1 << VEC_W) - 1;

   if (VEC_W < 5 || VEC_W > 16) begin : g_chk_w
      $error("exc_prio_resolver: VEC_W out of range");
   end
   if (RESET_VEC > VEC_MAX || MCHK_VEC > VEC_MAX || INIT_VEC > VEC_MAX ||
       SMI_VEC > VEC_MAX || NMI_VEC > VEC_MAX || UD_VEC > VEC_MAX) begin : g_chk_v
      $error("exc_prio_resolver: fixed vector exceeds VEC_W");
   end

   logic [NSRC-1:0] elig, grant;
   logic [IW-1:0]   win;
   logic            any, issue, nmi_ok, busy_q;
   exc_class_e      cls_d;
   logic [VEC_W-1:0] vec_d;

   exc_nmi_gate u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .nmi_in   (nmi_in),
      .take     (issue & grant[SRC_NMI]),
      .iret     (iret),
      .eligible (nmi_ok)
   );

   always_comb begin
      elig            = '0;
      elig[SRC_RST]   = rst_req;
      elig[SRC_MCHK]  = mchk_req;
      elig[SRC_INIT]  = init_req;
      elig[SRC_SMI]   = smi_req;
      elig[SRC_TRAP]  = trap_req;
      elig[SRC_NMI]   = nmi_ok;
      elig[SRC_IRQ]   = irq_req & irq_en;
      elig[SRC_EXE]   = exe_req;
      elig[SRC_FETCH] = fetch_req;
      elig[SRC_UD]    = ud_req;
   end

   exc_prio_penc #(.N(NSRC)) u_penc (
      .req   (elig),
      .grant (grant),
      .idx   (win),
      .any   (any)
   );

   assign issue = any & ~busy_q;

   always_comb begin
      cls_d = CLS_FAULT;
      vec_d = '0;
      case (int'(win))
         SRC_RST:   begin cls_d = CLS_ABORT; vec_d = RESET_VEC[VEC_W-1:0]; end
         SRC_MCHK:  begin cls_d = CLS_ABORT; vec_d = MCHK_VEC[VEC_W-1:0];  end
         SRC_INIT:  begin cls_d = CLS_INTR;  vec_d = INIT_VEC[VEC_W-1:0];  end
         SRC_SMI:   begin cls_d = CLS_INTR;  vec_d = SMI_VEC[VEC_W-1:0];   end
         SRC_TRAP:  begin cls_d = CLS_TRAP;  vec_d = trap_vec;             end
         SRC_NMI:   begin cls_d = CLS_INTR;  vec_d = NMI_VEC[VEC_W-1:0];   end
         SRC_IRQ:   begin cls_d = CLS_INTR;  vec_d = irq_vec;              end
         SRC_EXE:   begin cls_d = CLS_FAULT; vec_d = exe_vec;              end
         SRC_FETCH: begin cls_d = CLS_FAULT; vec_d = fetch_vec;            end
         default:   begin cls_d = CLS_FAULT; vec_d = UD_VEC[VEC_W-1:0];    end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         exc_valid <= 1'b0;
         exc_class <= 2'd0;
         exc_vec   <= '0;
      end else begin
         exc_valid <= issue;
         if (issue) begin
            busy_q    <= 1'b1;
            exc_class <= cls_d;
            exc_vec   <= vec_d;
         end else if (entry_done) begin
            busy_q    <= 1'b0;
         end
      end
   end

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> !exc_valid);
   assert_mask_honoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && grant[SRC_IRQ]) |-> irq_en);
   assert_abort_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_class == 2'd3) |-> $past(rst_req || mchk_req));
   assert_no_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !entry_done) |=> !exc_valid);

endmodule

// File: tb/exc_prio_resolver_test.sv
`timescale 1ns/1ps
module exc_prio_resolver_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [9:0] rq = '0;
   logic [7:0] trap_vec = '0, irq_vec = '0, exe_vec = '0, fetch_vec = '0;
   logic irq_en = 1'b0, entry_done = 1'b0, iret = 1'b0;
   logic exc_valid;
   logic [1:0] exc_class;
   logic [7:0] exc_vec;

   int total = 0, bad = 0, seen = 0, cyc = 0;
   int q_cls[$], q_vec[$];
   string q_tag[$];
   logic prev_valid = 1'b0;

   always #10 clk = ~clk;

   exc_prio_resolver uut (
      .clk(clk), .rst_n(rst_n),
      .rst_req(rq[0]), .mchk_req(rq[1]), .init_req(rq[2]), .smi_req(rq[3]),
      .trap_req(rq[4]), .trap_vec(trap_vec), .nmi_in(rq[5]),
      .irq_req(rq[6]), .irq_vec(irq_vec), .irq_en(irq_en),
      .exe_req(rq[7]), .exe_vec(exe_vec), .fetch_req(rq[8]), .fetch_vec(fetch_vec),
      .ud_req(rq[9]), .entry_done(entry_done), .iret(iret),
      .exc_valid(exc_valid), .exc_class(exc_class), .exc_vec(exc_vec)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input int c, input int v, input string tag);
      q_cls.push_back(c); q_vec.push_back(v); q_tag.push_back(tag);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && exc_valid) begin
         seen++;
         chk(!prev_valid, "R8 strobe width", 1, 0);
         if (q_cls.size() == 0) begin
            chk(0, "R5/R7 unexpected strobe", exc_vec, -1);
         end else begin
            int c, v;
            string t;
            c = q_cls.pop_front(); v = q_vec.pop_front(); t = q_tag.pop_front();
            chk(exc_class == c[1:0], {t, " class"}, exc_class, c);
            chk(exc_vec == v[7:0], {t, " vector"}, exc_vec, v);
         end
      end
      prev_valid = rst_n & exc_valid;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   // wait for a strobe, then drop source d (if d>=0) and pulse entry_done
   task automatic serve(input int d, input string tag);
      int s0;
      bit got;
      s0 = seen; got = 0;
      for (int i = 0; i < 30 && !got; i++) begin
         tick(1);
         if (seen != s0) got = 1;
      end
      chk(got, {tag, " strobe arrival"}, got, 1);
      if (d >= 0) rq[d] = 1'b0;
      entry_done = 1'b1;
      tick(1);
      entry_done = 1'b0;
   endtask

   task automatic pulse_iret();
      iret = 1'b1; tick(1); iret = 1'b0;
   endtask

   initial begin
      int s0;
      tick(3);
      chk(exc_valid == 1'b0, "R1 in reset", exc_valid, 0);
      rst_n = 1'b1;
      tick(3);
      chk(exc_valid == 1'b0, "R1 after reset", exc_valid, 0);

      // R2 R3 R4 R9: everything at once, drained in priority order
      trap_vec = 8'h21; irq_vec = 8'h40; exe_vec = 8'h0E; fetch_vec = 8'h0D;
      irq_en = 1'b1;
      expect_ev(3, 255, "R2 R3 R4 reset");
      expect_ev(3, 18,  "R2 R3 R4 mcheck");
      expect_ev(2, 254, "R2 R3 R4 init");
      expect_ev(2, 253, "R2 R3 R4 smi");
      expect_ev(1, 8'h21, "R2 R10 trap");
      expect_ev(2, 2,   "R2 R6 nmi");
      expect_ev(2, 8'h40, "R2 R5 irq");
      expect_ev(0, 8'h0E, "R2 R9 exe");
      expect_ev(0, 8'h0D, "R2 R9 fetch");
      expect_ev(0, 6,   "R2 R4 illegal");
      rq = 10'h3FF;
      for (int k = 0; k < 10; k++) serve(k, "R9 drain");

      // R7: second NMI edge blocked while handler active; exe fault still goes
      rq[5] = 1'b1; exe_vec = 8'h11; rq[7] = 1'b1;
      expect_ev(0, 8'h11, "R7 nested exe");
      serve(7, "R7 nested");
      s0 = seen;
      tick(6);
      chk(seen == s0, "R7 nmi held", seen - s0, 0);
      rq[5] = 1'b0;
      expect_ev(2, 2, "R7 nmi after iret");
      pulse_iret();
      serve(-1, "R7 release");
      pulse_iret();

      // R5: masked interrupt ignored
      irq_en = 1'b0; irq_vec = 8'h55; rq[6] = 1'b1;
      s0 = seen;
      tick(8);
      chk(seen == s0, "R5 masked", seen - s0, 0);
      expect_ev(2, 8'h55, "R5 unmasked irq");
      irq_en = 1'b1;
      serve(6, "R5 unmasked");

      // R6: NMI edge with mask clear, line drops before it is taken
      irq_en = 1'b0;
      rq[5] = 1'b1; tick(1); rq[5] = 1'b0;
      expect_ev(2, 2, "R6 nmi unmasked");
      serve(-1, "R6 nmi");
      pulse_iret();

      // R10: software trap vectors, mask clear
      trap_vec = 8'h80; rq[4] = 1'b1;
      expect_ev(1, 8'h80, "R10 trap 0x80");
      serve(4, "R10 a");
      trap_vec = 8'h03; rq[4] = 1'b1;
      expect_ev(1, 8'h03, "R10 trap 0x03");
      serve(4, "R10 b");

      // R8 R9: held request, one strobe until entry_done, then re-presented
      fetch_vec = 8'h0E; rq[8] = 1'b1;
      expect_ev(0, 8'h0E, "R8 first");
      expect_ev(0, 8'h0E, "R9 again");
      s0 = seen;
      tick(10);
      chk(seen - s0 == 1, "R8 single strobe while busy", seen - s0, 1);
      entry_done = 1'b1; tick(1); entry_done = 1'b0;
      serve(8, "R9 re-present");

      tick(4);
      chk(q_cls.size() == 0, "R9 all expected events seen", q_cls.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule